// File: doc/BRIEF.md
# Variable-Length Instruction Operand Extractor

This block sits after the instruction fetch stage of a byte-coded processor. Each cycle it can accept one instruction: the opcode byte, up to four bytes that follow it, the program counter of the opcode, and a 4-bit format code. The format code comes from an opcode classifier outside this block.

From these inputs the extractor works out how many bytes the instruction uses. It then builds every immediate form a later stage might want:
- the first operand byte, zero-extended and sign-extended;
- the little-endian halfword, in both extensions;
- the little-endian 32-bit word;
- the second operand byte, whole and split into its two nibbles;
- the two nibbles of the opcode byte.

It also computes the address of the next instruction and a short-branch target. All results appear one clock after the request, in a single registered stage. Bytes that lie past the end of the instruction are forced to zero before any form is built, so no form carries stray bytes from the instruction that follows.

Top module: `opx_operand_extract`

## Requirements
- R1: Format code to length: 0 implicit gives 1 byte, 1 byte-literal gives 2, 2 double-byte gives 3, 3 quad-byte gives 5, 4 jump-byte-byte gives 3, 5 local-register gives 1, 6 local-register-byte gives 2, 7 register-register-byte gives 3, 8 register-register gives 3, 9 register-jump gives 3.
- R2: Format codes 10 to 15 are treated as implicit, with a length of 1.
- R3: `out_next_pc` equals the request's PC plus the length, taken modulo 2^32.
- R4: `out_alpha_z` is the first operand byte (bits 15:8 of `in_bytes`) zero-extended to 32 bits. `out_alpha_s` is the same byte sign-extended from its bit 7.
- R5: `out_hw_z` and `out_hw_s` hold first + 256*second operand byte, zero-extended and sign-extended from bit 15 respectively.
- R6: `out_word` equals first + 2^8*second + 2^16*third + 2^24*fourth operand byte.
- R7: `out_beta_z` is the second operand byte zero-extended. `out_beta_hi` is its bits 7:4 and `out_beta_lo` is its bits 3:0.
- R8: `out_op_hi` is bits 7:4 and `out_op_lo` is bits 3:0 of the opcode byte (`in_bytes[7:0]`). In the local-register format these two fields are the operation and the register number.
- R9: `out_branch_tgt` equals PC + `out_alpha_s`, modulo 2^32.
- R10: An operand byte at position k (1 to 4) with k >= length counts as zero in every derived output.
- R11: The outputs update one clock after a request with `in_valid` high, and `out_valid` follows `in_valid` by one clock. While `in_valid` is low, the data outputs keep their values.
- R12: A synchronous active-low reset clears `out_valid` and every data output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_fmt | input | 4 | Format code of the instruction |
| in_pc | input | 32 | Address of the opcode byte |
| in_bytes | input | 40 | Opcode byte in bits 7:0, operand byte k in bits 8k+7:8k |
| out_valid | output | 1 | Results belong to a request taken last cycle |
| out_len | output | 3 | Instruction length in bytes |
| out_next_pc | output | 32 | PC plus length |
| out_branch_tgt | output | 32 | PC plus sign-extended first operand byte |
| out_alpha_z | output | 32 | First operand byte, zero-extended |
| out_alpha_s | output | 32 | First operand byte, sign-extended |
| out_hw_z | output | 32 | Unaligned halfword, zero-extended |
| out_hw_s | output | 32 | Unaligned halfword, sign-extended |
| out_word | output | 32 | Unaligned 32-bit operand |
| out_beta_z | output | 32 | Second operand byte, zero-extended |
| out_beta_hi | output | 4 | Upper nibble of the second operand byte |
| out_beta_lo | output | 4 | Lower nibble of the second operand byte |
| out_op_hi | output | 4 | Upper nibble of the opcode byte |
| out_op_lo | output | 4 | Lower nibble of the opcode byte |

## Verification
Every format code, including the six unused ones, is driven with random operand bytes. This separates a wrong length from a wrong mask: either fault leaves the wrong bytes alive in the word and halfword forms.

Directed patterns use bytes with bit 7 or bit 15 set, and all-ones words, so that sign extension is told apart from zero extension. A PC close to 2^32 exposes any carry that is not wrapped in the next-PC and branch-target sums.

Idle cycles carrying changed inputs show whether the register stage holds its values or tracks the inputs.

// File: rtl/opx_pkg.sv
// Shared types for the operand extractor.
// Assumes a byte-addressed instruction stream with at most four operand bytes.
package opx_pkg;
    localparam int BYTE_W   = 8;
    localparam int MAX_OPND = 4;
    localparam int LEN_W    = 3;
    localparam int FMT_W    = 4;

    typedef enum logic [FMT_W-1:0] {
        FMT_IMPL = 4'd0,
        FMT_BYTE = 4'd1,
        FMT_DBYT = 4'd2,
        FMT_QBYT = 4'd3,
        FMT_JBB  = 4'd4,
        FMT_LREG = 4'd5,
        FMT_LRB  = 4'd6,
        FMT_RRB  = 4'd7,
        FMT_RR   = 4'd8,
        FMT_RJMP = 4'd9
    } fmt_e;
endpackage

// File: rtl/opx_len_dec.sv
// Maps a format code to an instruction length in bytes.
// Assumes unused codes behave as the implicit format.
module opx_len_dec
    import opx_pkg::*;
(
    input  logic [FMT_W-1:0] fmt,
    output logic [LEN_W-1:0] len
);
    // Decode the length of each format.
    always_comb begin
        case (fmt)
            FMT_BYTE, FMT_LRB:                    len = 3'd2;
            FMT_DBYT, FMT_JBB, FMT_RRB,
            FMT_RR,   FMT_RJMP:                   len = 3'd3;
            FMT_QBYT:                             len = 3'd5;
            default:                              len = 3'd1;
        endcase
    end
endmodule

// File: rtl/opx_byte_mask.sv
// Zeroes every operand byte whose position lies at or beyond the instruction length.
// Assumes the opcode sits in byte 0 and is always kept.
module opx_byte_mask
    import opx_pkg::*;
#(
    parameter int NBYTES = MAX_OPND + 1,
    localparam int W     = NBYTES * BYTE_W
)(
    input  logic [W-1:0]     raw,
    input  logic [LEN_W-1:0] len,
    output logic [W-1:0]     kept
);
    assign kept[BYTE_W-1:0] = raw[BYTE_W-1:0];

    for (genvar k = 1; k < NBYTES; k++) begin : g_byte
        // Keep the byte only when it belongs to the instruction.
        assign kept[k*BYTE_W +: BYTE_W] =
            (LEN_W'(k) < len) ? raw[k*BYTE_W +: BYTE_W] : '0;
    end
endmodule

// File: rtl/opx_imm_build.sv
// Builds the immediate forms from the masked bytes, plus the next PC and branch target.
// Assumes little-endian byte order and 32-bit address arithmetic that wraps.
module opx_imm_build
    import opx_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NB_W  = (MAX_OPND + 1) * BYTE_W
)(
    input  logic [NB_W-1:0]   bytes_m,
    input  logic [LEN_W-1:0]  len,
    input  logic [DATA_W-1:0] pc,
    output logic [DATA_W-1:0] next_pc,
    output logic [DATA_W-1:0] branch_tgt,
    output logic [DATA_W-1:0] alpha_z,
    output logic [DATA_W-1:0] alpha_s,
    output logic [DATA_W-1:0] hw_z,
    output logic [DATA_W-1:0] hw_s,
    output logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] beta_z,
    output logic [3:0]        beta_hi,
    output logic [3:0]        beta_lo,
    output logic [3:0]        op_hi,
    output logic [3:0]        op_lo
);
    logic [BYTE_W-1:0]   op_b, alpha_b, beta_b;
    logic [2*BYTE_W-1:0] half;

    assign op_b    = bytes_m[0 +: BYTE_W];
    assign alpha_b = bytes_m[BYTE_W +: BYTE_W];
    assign beta_b  = bytes_m[2*BYTE_W +: BYTE_W];
    assign half    = bytes_m[BYTE_W +: 2*BYTE_W];

    // Form the extended immediates and the address sums.
    always_comb begin
        alpha_z    = DATA_W'(alpha_b);
        alpha_s    = {{(DATA_W-BYTE_W){alpha_b[BYTE_W-1]}}, alpha_b};
        hw_z       = DATA_W'(half);
        hw_s       = {{(DATA_W-2*BYTE_W){half[2*BYTE_W-1]}}, half};
        word       = bytes_m[BYTE_W +: DATA_W];
        beta_z     = DATA_W'(beta_b);
        beta_hi    = beta_b[7:4];
        beta_lo    = beta_b[3:0];
        op_hi      = op_b[7:4];
        op_lo      = op_b[3:0];
        next_pc    = pc + DATA_W'(len);
        branch_tgt = pc + alpha_s;
    end
endmodule

// File: rtl/opx_operand_extract.sv
// Top level: decodes the length, masks the bytes, builds the immediates and registers the results.
// Assumes the format code has already been derived from the opcode. The latency is one clock.
module opx_operand_extract
    import opx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [3:0]  in_fmt,
    input  logic [31:0] in_pc,
    input  logic [39:0] in_bytes,
    output logic        out_valid,
    output logic [2:0]  out_len,
    output logic [31:0] out_next_pc,
    output logic [31:0] out_branch_tgt,
    output logic [31:0] out_alpha_z,
    output logic [31:0] out_alpha_s,
    output logic [31:0] out_hw_z,
    output logic [31:0] out_hw_s,
    output logic [31:0] out_word,
    output logic [31:0] out_beta_z,
    output logic [3:0]  out_beta_hi,
    output logic [3:0]  out_beta_lo,
    output logic [3:0]  out_op_hi,
    output logic [3:0]  out_op_lo
);
    logic [LEN_W-1:0] len_c;
    logic [39:0]      bytes_m;
    logic [31:0]      npc_c, tgt_c, az_c, as_c, hz_c, hs_c, w_c, bz_c;
    logic [3:0]       bh_c, bl_c, oh_c, ol_c;

    opx_len_dec u_len (.fmt(in_fmt), .len(len_c));

    opx_byte_mask #(.NBYTES(MAX_OPND + 1)) u_mask (
        .raw(in_bytes), .len(len_c), .kept(bytes_m));

    opx_imm_build #(.DATA_W(32)) u_imm (
        .bytes_m(bytes_m), .len(len_c), .pc(in_pc),
        .next_pc(npc_c), .branch_tgt(tgt_c),
        .alpha_z(az_c), .alpha_s(as_c), .hw_z(hz_c), .hw_s(hs_c),
        .word(w_c), .beta_z(bz_c), .beta_hi(bh_c), .beta_lo(bl_c),
        .op_hi(oh_c), .op_lo(ol_c));

    // Valid flag follows the request by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Capture the results of each accepted request; hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_len <= '0;        out_next_pc <= '0;  out_branch_tgt <= '0;
            out_alpha_z <= '0;    out_alpha_s <= '0;  out_hw_z <= '0;
            out_hw_s <= '0;       out_word <= '0;     out_beta_z <= '0;
            out_beta_hi <= '0;    out_beta_lo <= '0;
            out_op_hi <= '0;      out_op_lo <= '0;
        end else if (in_valid) begin
            out_len <= len_c;     out_next_pc <= npc_c; out_branch_tgt <= tgt_c;
            out_alpha_z <= az_c;  out_alpha_s <= as_c;  out_hw_z <= hz_c;
            out_hw_s <= hs_c;     out_word <= w_c;      out_beta_z <= bz_c;
            out_beta_hi <= bh_c;  out_beta_lo <= bl_c;
            out_op_hi <= oh_c;    out_op_lo <= ol_c;
        end
    end

    // R1: every reported length is one of the legal lengths.
    p_len_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len == 3'd1 || out_len == 3'd2 || out_len == 3'd3 || out_len == 3'd5));

    // R3: the next PC is the captured PC plus the reported length.
    p_next_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_next_pc == $past(in_pc) + 32'(out_len));

    // R4: both extensions of the first operand byte agree on their low byte.
    p_alpha_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_alpha_s[7:0] == out_alpha_z[7:0] && out_alpha_z[31:8] == 24'd0));

    // R10: a 1-byte instruction leaves every operand form at zero.
    p_mask_short_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_len == 3'd1) |-> (out_word == 32'd0 && out_branch_tgt == $past(in_pc)));

    // R11: the data outputs stay unchanged after an idle cycle.
    p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && $past(rst_n)) |=> ($stable(out_word) && $stable(out_next_pc) && !out_valid));
endmodule

// File: tb/opx_operand_extract_tb.sv
// Bench for the operand extractor: random requests under a fixed seed plus directed corner cases.
module opx_operand_extract_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_fmt = '0;
    logic [31:0] in_pc = '0;
    logic [39:0] in_bytes = '0;
    logic        out_valid;
    logic [2:0]  out_len;
    logic [31:0] out_next_pc, out_branch_tgt, out_alpha_z, out_alpha_s;
    logic [31:0] out_hw_z, out_hw_s, out_word, out_beta_z;
    logic [3:0]  out_beta_hi, out_beta_lo, out_op_hi, out_op_lo;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opx_operand_extract dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fmt(in_fmt),
        .in_pc(in_pc), .in_bytes(in_bytes), .out_valid(out_valid),
        .out_len(out_len), .out_next_pc(out_next_pc), .out_branch_tgt(out_branch_tgt),
        .out_alpha_z(out_alpha_z), .out_alpha_s(out_alpha_s), .out_hw_z(out_hw_z),
        .out_hw_s(out_hw_s), .out_word(out_word), .out_beta_z(out_beta_z),
        .out_beta_hi(out_beta_hi), .out_beta_lo(out_beta_lo),
        .out_op_hi(out_op_hi), .out_op_lo(out_op_lo));

    // Expected length, taken from the format table in the requirements.
    function automatic logic [2:0] exp_len(input logic [3:0] f);
        case (f)
            4'd1, 4'd6:                     return 3'd2;
            4'd2, 4'd4, 4'd7, 4'd8, 4'd9:   return 3'd3;
            4'd3:                           return 3'd5;
            default:                        return 3'd1;
        endcase
    endfunction

    // Operand byte k, or zero when the byte lies past the instruction's end.
    function automatic logic [7:0] exp_byte(input logic [39:0] b, input logic [3:0] f, input int k);
        if (k != 0 && k >= int'(exp_len(f))) return 8'd0;
        return b[8*k +: 8];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] f, input logic [31:0] pc, input logic [39:0] b);
        logic [7:0] a, be, g, d;
        logic [2:0] l;
        @(negedge clk);
        in_valid = 1'b1; in_fmt = f; in_pc = pc; in_bytes = b;
        @(posedge clk);
        #1;
        l  = exp_len(f);
        a  = exp_byte(b, f, 1); be = exp_byte(b, f, 2);
        g  = exp_byte(b, f, 3); d  = exp_byte(b, f, 4);
        chk(f > 4'd9 ? "R2 len" : "R1 len", 32'(out_len), 32'(l));
        chk("R11 valid", 32'(out_valid), 32'd1);
        chk("R3 next_pc", out_next_pc, pc + 32'(l));
        chk("R4 alpha_z", out_alpha_z, {24'd0, a});
        chk("R4 alpha_s", out_alpha_s, {{24{a[7]}}, a});
        chk("R5 hw_z", out_hw_z, {16'd0, be, a});
        chk("R5 hw_s", out_hw_s, {{16{be[7]}}, be, a});
        chk("R6/R10 word", out_word, {d, g, be, a});
        chk("R7 beta_z", out_beta_z, {24'd0, be});
        chk("R7 beta_hi", 32'(out_beta_hi), 32'(be[7:4]));
        chk("R7 beta_lo", 32'(out_beta_lo), 32'(be[3:0]));
        chk("R8 op_hi", 32'(out_op_hi), 32'(b[7:4]));
        chk("R8 op_lo", 32'(out_op_lo), 32'(b[3:0]));
        chk("R9 branch", out_branch_tgt, pc + {{24{a[7]}}, a});
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        logic [31:0] held_w, held_pc;
        seed_init = $urandom(32'd20240);
        repeat (3) @(posedge clk);
        #1;
        // R12: reset clears every output.
        chk("R12 valid", 32'(out_valid), 32'd0);
        chk("R12 word", out_word, 32'd0);
        chk("R12 next_pc", out_next_pc, 32'd0);
        chk("R12 len", 32'(out_len), 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // Directed cases: every format with sign-heavy bytes.
        for (int f = 0; f < 16; f++) run(4'(f), 32'h0000_1000, 40'hFF_EE_80_93_A5);
        // R3, R9: address sums that wrap past 2^32.
        run(4'd3, 32'hFFFF_FFFE, 40'h12_34_56_7F_01);
        run(4'd4, 32'h0000_0010, 40'h00_00_05_F0_11);
        run(4'd2, 32'hFFFF_FFFF, 40'hFF_FF_FF_FF_FF);
        // R8: local-register format splits the opcode into operation and register.
        run(4'd5, 32'h0000_2000, 40'hAA_BB_CC_DD_7C);

        // R11: an idle cycle with changed inputs leaves the data outputs in place.
        held_w = out_word; held_pc = out_next_pc;
        @(negedge clk);
        in_valid = 1'b0; in_fmt = 4'd3; in_bytes = 40'h11_22_33_44_55; in_pc = 32'h1;
        @(posedge clk); #1;
        chk("R11 idle valid", 32'(out_valid), 32'd0);
        chk("R11 idle word", out_word, held_w);
        chk("R11 idle next_pc", out_next_pc, held_pc);

        // Random requests.
        for (int i = 0; i < 400; i++)
            run(4'($urandom_range(0, 15)), $urandom, {8'($urandom), $urandom});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule